// File: doc/BRIEF.md
# Two-Threshold Runt Pulse Detector

This block watches a stream of unsigned sample codes, one per clock, and flags runt pulses. A runt is an excursion that leaves one of two programmed threshold regions, spends time between the thresholds, and then falls back to where it started without ever reaching the opposite threshold. A swing that passes both thresholds is a normal edge and never fires the detector. Narrow excursions are treated as noise: a runt counts only if the signal stayed between the thresholds for at least a programmed number of samples.

Each sample is sorted into one of three regions: below the low code, above the high code, or between them. A state machine remembers which outer region the signal left when it entered the middle. A saturating counter measures how long it stayed there. When the signal comes back to the outer region it left, the counter is compared with the minimum width. The two polarity enables then decide whether the block emits a single-clock trigger. After reset the block does nothing until it has seen the signal in one of the two outer regions.

Top module: `runt_detector`

## Requirements
- R1: A sample below `thr_lo_i` is in the low region. A sample above `thr_hi_i` is in the high region. Every other sample is between, and this includes samples exactly equal to either threshold code. `thr_lo_i` must be below `thr_hi_i`.
- R2: A positive runt fires. The signal is in the low region, then one or more between samples follow, then a low-region sample arrives. `trig_o` is high in the clock cycle after the edge that captures that low-region sample.
- R3: A negative runt fires. The signal is in the high region, then one or more between samples follow, then a high-region sample arrives. `trig_o` is high in the clock cycle after the edge that captures that high-region sample.
- R4: A full transition never fires. This covers low to high and high to low, whether the swing is direct or passes through the between region.
- R5: A runt qualifies only if the number of consecutive between samples is at least `min_width_i`. Fewer samples give no trigger. A `min_width_i` of 0 accepts any runt.
- R6: `pol_pos_en_i` gates positive runts and `pol_neg_en_i` gates negative runts. Both may be set at once.
- R7: The between-sample counter saturates at 2^CNT_W-1. An excursion longer than that still qualifies against a `min_width_i` of 2^CNT_W-1.
- R8: While `rst_n` is low, `trig_o` is 0. After reset the block forgets any excursion in progress. No trigger can occur until a sample has been seen in the low or high region.
- R9: `trig_o` is a single-cycle pulse and is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_i | input | SAMPLE_W | Unsigned sample code, one per clock |
| thr_lo_i | input | SAMPLE_W | Low threshold code |
| thr_hi_i | input | SAMPLE_W | High threshold code |
| pol_pos_en_i | input | 1 | Enable for positive runts (low-start) |
| pol_neg_en_i | input | 1 | Enable for negative runts (high-start) |
| min_width_i | input | CNT_W | Minimum number of between samples for a runt to qualify |
| trig_o | output | 1 | One-cycle trigger when a qualifying runt ends |

## Verification
Thresholds are fixed at 100 and 200. Several sample patterns then probe the detector.

- Short and long low-start excursions separate noise rejection from a real positive runt.
- High-start excursions exercise the mirrored negative case.
- Direct jumps, and swings through the middle into the far region, show that full transitions never fire.
- Samples equal to and one code away from each threshold pin down the region boundaries.
- Runs that are exactly the minimum width, and one sample short of it, fix the qualifying comparison.
- A run longer than the counter range checks saturation.
- One-sided polarity settings and a reset in the middle of an excursion show that each enable gates only its own runt type, and that reset discards an excursion in progress.

// File: rtl/rd_pkg.sv
package rd_pkg;

  typedef enum logic [1:0] {
    REG_LOW  = 2'd0,
    REG_MID  = 2'd1,
    REG_HIGH = 2'd2
  } region_e;

  typedef enum logic [2:0] {
    ST_UNARMED   = 3'd0,
    ST_AT_LOW    = 3'd1,
    ST_AT_HIGH   = 3'd2,
    ST_MID_FROM_LO = 3'd3,
    ST_MID_FROM_HI = 3'd4
  } state_e;

endpackage

// File: rtl/rd_classifier.sv
module rd_classifier #(
  parameter int SAMPLE_W = 12
) (
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  output rd_pkg::region_e     region_o
);
  import rd_pkg::*;

  // R1: threshold codes themselves belong to the between region
  function automatic region_e classify(
    input logic [SAMPLE_W-1:0] s,
    input logic [SAMPLE_W-1:0] lo,
    input logic [SAMPLE_W-1:0] hi
  );
    if (s < lo)      return REG_LOW;
    else if (s > hi) return REG_HIGH;
    else             return REG_MID;
  endfunction

  assign region_o = classify(sample_i, thr_lo_i, thr_hi_i);

endmodule

// File: rtl/rd_width_counter.sv
module rd_width_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // R7: saturating increment
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
    return (v == CNT_MAX) ? CNT_MAX : v + CNT_ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_o <= '0;
    else if (start_i) cnt_o <= CNT_ONE;
    else if (inc_i)   cnt_o <= sat_inc(cnt_o);
  end

endmodule

// File: rtl/rd_fsm.sv
module rd_fsm #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rd_pkg::region_e  region_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] min_width_i,
  input  logic             pol_pos_en_i,
  input  logic             pol_neg_en_i,
  output rd_pkg::state_e   state_o,
  output logic             cnt_start_o,
  output logic             cnt_inc_o,
  output logic             ret_low_o,
  output logic             ret_high_o,
  output logic             trig_o
);
  import rd_pkg::*;

  state_e state_q, state_d;
  logic   fire;

  // R5: width qualification
  function automatic logic wide_enough(
    input logic [CNT_W-1:0] w,
    input logic [CNT_W-1:0] m
  );
    return w >= m;
  endfunction

  always_comb begin
    state_d     = state_q;
    cnt_start_o = 1'b0;
    cnt_inc_o   = 1'b0;
    ret_low_o   = 1'b0;
    ret_high_o  = 1'b0;
    unique case (state_q)
      ST_UNARMED: begin
        if (region_i == REG_LOW)       state_d = ST_AT_LOW;
        else if (region_i == REG_HIGH) state_d = ST_AT_HIGH;
      end
      ST_AT_LOW: begin
        if (region_i == REG_MID) begin
          state_d     = ST_MID_FROM_LO;
          cnt_start_o = 1'b1;
        end else if (region_i == REG_HIGH) begin
          state_d = ST_AT_HIGH;
        end
      end
      ST_AT_HIGH: begin
        if (region_i == REG_MID) begin
          state_d     = ST_MID_FROM_HI;
          cnt_start_o = 1'b1;
        end else if (region_i == REG_LOW) begin
          state_d = ST_AT_LOW;
        end
      end
      ST_MID_FROM_LO: begin
        if (region_i == REG_MID) begin
          cnt_inc_o = 1'b1;
        end else if (region_i == REG_LOW) begin
          state_d   = ST_AT_LOW;
          ret_low_o = 1'b1;
        end else begin
          state_d = ST_AT_HIGH;
        end
      end
      ST_MID_FROM_HI: begin
        if (region_i == REG_MID) begin
          cnt_inc_o = 1'b1;
        end else if (region_i == REG_HIGH) begin
          state_d    = ST_AT_HIGH;
          ret_high_o = 1'b1;
        end else begin
          state_d = ST_AT_LOW;
        end
      end
      default: state_d = ST_UNARMED;
    endcase
  end

  assign fire = wide_enough(cnt_i, min_width_i) &&
                ((ret_low_o && pol_pos_en_i) || (ret_high_o && pol_neg_en_i));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_UNARMED;
      trig_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      trig_o  <= fire;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/runt_detector.sv
module runt_detector #(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [SAMPLE_W-1:0] thr_lo_i,
  input  logic [SAMPLE_W-1:0] thr_hi_i,
  input  logic                pol_pos_en_i,
  input  logic                pol_neg_en_i,
  input  logic [CNT_W-1:0]    min_width_i,
  output logic                trig_o
);
  import rd_pkg::*;

  region_e          region;
  state_e           state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_start;
  logic             cnt_inc;
  logic             ret_low;
  logic             ret_high;

  rd_classifier #(.SAMPLE_W(SAMPLE_W)) u_cls (
    .sample_i (sample_i),
    .thr_lo_i (thr_lo_i),
    .thr_hi_i (thr_hi_i),
    .region_o (region)
  );

  rd_width_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (cnt_start),
    .inc_i   (cnt_inc),
    .cnt_o   (cnt)
  );

  rd_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .region_i     (region),
    .cnt_i        (cnt),
    .min_width_i  (min_width_i),
    .pol_pos_en_i (pol_pos_en_i),
    .pol_neg_en_i (pol_neg_en_i),
    .state_o      (state),
    .cnt_start_o  (cnt_start),
    .cnt_inc_o    (cnt_inc),
    .ret_low_o    (ret_low),
    .ret_high_o   (ret_high),
    .trig_o       (trig_o)
  );

endmodule

// File: rtl/rd_checker.sv
module rd_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             trig_o,
  input rd_pkg::state_e   state,
  input rd_pkg::region_e  region,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] min_width_i,
  input logic             pol_pos_en_i,
  input logic             pol_neg_en_i,
  input logic             ret_low,
  input logic             ret_high
);
  import rd_pkg::*;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |=> !trig_o);

  // R4
  full_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_MID_FROM_LO || state == ST_AT_LOW) && region == REG_HIGH) |=> !trig_o);

  // R4
  full_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_MID_FROM_HI || state == ST_AT_HIGH) && region == REG_LOW) |=> !trig_o);

  // R5
  min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> ($past(cnt) >= $past(min_width_i)));

  // R6
  pos_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && state == ST_AT_LOW) |-> $past(pol_pos_en_i));

  // R6
  neg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o && state == ST_AT_HIGH) |-> $past(pol_neg_en_i));

  // R2
  pos_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_low && pol_pos_en_i && cnt >= min_width_i) |=> (trig_o && state == ST_AT_LOW));

  // R3
  neg_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_high && pol_neg_en_i && cnt >= min_width_i) |=> (trig_o && state == ST_AT_HIGH));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_MID_FROM_LO || state == ST_MID_FROM_HI) &&
     $past(state) == state && $past(cnt) == CNT_MAX) |-> (cnt == CNT_MAX));

  // R8
  unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_UNARMED) |=> !trig_o);

endmodule

bind runt_detector rd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .trig_o       (trig_o),
  .state        (state),
  .region       (region),
  .cnt          (cnt),
  .min_width_i  (min_width_i),
  .pol_pos_en_i (pol_pos_en_i),
  .pol_neg_en_i (pol_neg_en_i),
  .ret_low      (ret_low),
  .ret_high     (ret_high)
);

// File: tb/sim_runt_detector.sv
`timescale 1ns/1ps
module sim_runt_detector;
  localparam int SAMPLE_W = 12;
  localparam int CNT_W    = 8;
  localparam int NV       = 33;
  localparam int L = 50, M = 150, H = 250;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [SAMPLE_W-1:0] sample_i = '0;
  logic [SAMPLE_W-1:0] thr_lo_i = 12'd100;
  logic [SAMPLE_W-1:0] thr_hi_i = 12'd200;
  logic                pol_pos_en_i = 1'b1;
  logic                pol_neg_en_i = 1'b1;
  logic [CNT_W-1:0]    min_width_i = 8'd3;
  logic                trig_o;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  runt_detector #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .thr_lo_i(thr_lo_i),
    .thr_hi_i(thr_hi_i), .pol_pos_en_i(pol_pos_en_i), .pol_neg_en_i(pol_neg_en_i),
    .min_width_i(min_width_i), .trig_o(trig_o)
  );

  // Vector table, thresholds 100/200, min width 3, both polarities.
  // Tags: R8 unarmed start, R5 short run, R2 positive runt, R4 full swings,
  // R3 negative runt, R1 threshold-code boundaries.
  localparam int VS [NV] = '{
    M, L, M, M, L, M, M, M, L, M,
    H, M, M, M, M, H, L, H, M, M,
    M, L, 100, 200, 101, 99, 201, 200, 201, 199,
    150, 100, 201 };
  localparam int VT [NV] = '{
    0, 0, 0, 0, 0, 0, 0, 0, 1, 0,
    0, 0, 0, 0, 0, 1, 0, 0, 0, 0,
    0, 0, 0, 0, 0, 1, 0, 0, 0, 0,
    0, 0, 1 };
  localparam int VR [NV] = '{
    8, 8, 5, 5, 5, 2, 2, 2, 2, 4,
    4, 3, 3, 3, 3, 3, 4, 4, 4, 4,
    4, 4, 1, 1, 1, 1, 1, 3, 5, 3,
    3, 3, 3 };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s trig_o actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int s, output logic t);
    @(negedge clk);
    sample_i = s[SAMPLE_W-1:0];
    @(posedge clk);
    #1;
    t = trig_o;
  endtask

  task automatic run_mid(input int n);
    logic t;
    for (int k = 0; k < n; k++) begin
      step(M, t);
      check("R9_mid_quiet", t, 1'b0);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic t;
    sample_i = M;
    repeat (3) @(posedge clk);
    #1;
    check("R8_reset", trig_o, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VS[i], t);
      checks++;
      if (t !== VT[i][0]) begin
        failures++;
        $display("FAIL R%0d vector %0d trig_o actual=%0b expected=%0b", VR[i], i, t, VT[i][0]);
      end
    end

    // R6: positive only; state is high-side now
    pol_pos_en_i = 1'b1; pol_neg_en_i = 1'b0;
    run_mid(3);
    step(H, t); check("R6_neg_blocked", t, 1'b0);
    step(L, t); check("R4_direct_fall", t, 1'b0);
    run_mid(3);
    step(L, t); check("R6_pos_allowed", t, 1'b1);

    // R6: negative only
    pol_pos_en_i = 1'b0; pol_neg_en_i = 1'b1;
    run_mid(3);
    step(L, t); check("R6_pos_blocked", t, 1'b0);
    step(H, t); check("R4_direct_rise", t, 1'b0);
    run_mid(3);
    step(H, t); check("R6_neg_allowed", t, 1'b1);

    // R5: minimum width zero accepts a single between sample
    pol_pos_en_i = 1'b1; pol_neg_en_i = 1'b1;
    min_width_i = 8'd0;
    run_mid(1);
    step(H, t); check("R5_zero_width", t, 1'b1);
    step(H, t); check("R9_no_repeat", t, 1'b0);

    // R5/R7: maximum width, one short then saturated
    min_width_i = 8'd255;
    step(L, t); check("R4_direct_fall2", t, 1'b0);
    run_mid(254);
    step(L, t); check("R5_one_short", t, 1'b0);
    run_mid(300);
    step(L, t); check("R7_saturated", t, 1'b1);

    // R8: reset in the middle of an excursion
    min_width_i = 8'd0;
    run_mid(2);
    @(negedge clk); rst_n = 1'b0; sample_i = M;
    @(posedge clk); #1;
    check("R8_in_reset", trig_o, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    run_mid(2);
    step(L, t); check("R8_excursion_forgotten", t, 1'b0);
    run_mid(1);
    step(L, t); check("R8_rearmed", t, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule